// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers interrupt requests from two 8-bit local status words, one shared 8-bit mapped status word and four single request lines: a high-priority timer, a bus error and two counter-timers. Each local word is qualified by its own mask register. One bit of each local word is a mapping bit. When that bit is pending, the choice for that local group is made from a secondary set instead: the shared mapped status word qualified by that group's own secondary mask. The secondary set then wins over every other bit of the local word.

A fixed-priority selector picks one winning category per clock. It reports the category code and, for the two local categories, a global interrupt number. The result is held in an output register, so it appears one cycle after the inputs that caused it. Pending sources that lose are reported in later cycles, once the winning source has been cleared at its origin.

Four mask registers are written and read through a small word-addressed port.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: A local group's pending set is its status word ANDed with its mask. A status bit whose mask bit is 0 never affects the result.
- R2: Within a pending set the highest-numbered set bit wins. The number reported is the group base plus the bit index. With the default IRQ_BASE of 8, local group 0 uses 8..15, local group 1 uses 16..23, mapped group 0 uses 24..31 and mapped group 1 uses 32..39.
- R3: When bit MAP_BIT0 (default 2) of local group 0's pending set is 1, the group's result is taken only from the mapped status ANDed with secondary mask 0. The other bits of local group 0 are ignored.
- R4: When bit MAP_BIT1 (default 3) of local group 1's pending set is 1, the group's result is taken from the same shared mapped status ANDed with secondary mask 1.
- R5: When a mapping bit is pending but its secondary pending set is zero, that local group reports nothing. Selection then moves on to the next lower category.
- R6: Category priority, highest first, is: timer (code 1), local group 0 (code 2), local group 1 (code 3), bus error (code 4), counter-timers (code 5). Code 0 means nothing is pending. irq_num is 0 for every category other than 2 and 3.
- R7: Either counter-timer line, or both together, gives category 5.
- R8: On a rising edge with reg_we high, reg_wdata is written to the mask register chosen by reg_addr: 0 is local mask 0, 1 is local mask 1, 2 is secondary mask 0, 3 is secondary mask 1. reg_rdata always shows the register chosen by reg_addr.
- R9: While reset is asserted, all four masks read 0 and the outputs are irq_valid=0, irq_cat=0 and irq_num=0.
- R10: The outputs show the inputs and masks as sampled at the previous rising edge. irq_valid is 1 exactly when irq_cat is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| loc0_stat | input | 8 | Local group 0 status |
| loc1_stat | input | 8 | Local group 1 status |
| map_stat | input | 8 | Shared mapped status |
| tmr_req | input | 1 | High-priority timer request |
| buserr_req | input | 1 | Bus error request |
| ctr0_req | input | 1 | Counter-timer 0 request |
| ctr1_req | input | 1 | Counter-timer 1 request |
| reg_we | input | 1 | Mask register write enable |
| reg_addr | input | 2 | Mask register word address |
| reg_wdata | input | 8 | Mask register write data |
| reg_rdata | output | 8 | Mask register read data |
| irq_valid | output | 1 | A source is reported |
| irq_cat | output | 3 | Winning category code |
| irq_num | output | 6 | Interrupt number for local categories, otherwise 0 |

## Verification
Two decisions can fall in the same cycle: a local group's own priority choice and the top-level selector's choice among categories. One case makes this concrete: a mapping bit is pending while its secondary set is empty, and a lower category is also requesting. The vector table drives these overlaps on purpose. It covers a drained secondary with local group 1 active, a drained secondary with only a bus error, and a timer together with a live local group. Each case is judged by the expected category and number for that cycle. A mask write that lands in the same cycle as a status change is covered separately. It is judged by sampling the output one edge later and checking that the new mask is in effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    CAT_NONE    = 3'd0,
    CAT_TIMER   = 3'd1,
    CAT_LOCAL0  = 3'd2,
    CAT_LOCAL1  = 3'd3,
    CAT_BUSERR  = 3'd4,
    CAT_COUNTER = 3'd5
  } irq_cat_e;

  localparam int GROUP_W   = 8;
  localparam int N_GROUPS  = 2;
  localparam int N_MASKS   = 2 * N_GROUPS;
endpackage

// File: rtl/irqc_hibit.sv
module irqc_hibit #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_group.sv
module irqc_group #(
  parameter int W        = 8,
  parameter int MAP_BIT  = 2,
  parameter int PRI_BASE = 8,
  parameter int SEC_BASE = 24,
  parameter int NUMW     = 6,
  localparam int IW      = $clog2(W)
) (
  input  logic [W-1:0]    stat,
  input  logic [W-1:0]    mask,
  input  logic [W-1:0]    map_stat,
  input  logic [W-1:0]    sec_mask,
  output logic            grp_valid,
  output logic [NUMW-1:0] grp_num
);
  logic [W-1:0]  pri_pend;
  logic [W-1:0]  sec_pend;
  logic          pri_found;
  logic          sec_found;
  logic [IW-1:0] pri_idx;
  logic [IW-1:0] sec_idx;
  logic          map_hit;

  assign pri_pend = stat & mask;
  assign sec_pend = map_stat & sec_mask;
  assign map_hit  = pri_pend[MAP_BIT];

  irqc_hibit #(.W(W)) u_pri (.vec(pri_pend), .found(pri_found), .idx(pri_idx));
  irqc_hibit #(.W(W)) u_sec (.vec(sec_pend), .found(sec_found), .idx(sec_idx));

  always_comb begin
    grp_valid = 1'b0;
    grp_num   = '0;
    if (map_hit) begin
      if (sec_found) begin
        grp_valid = 1'b1;
        grp_num   = NUMW'(SEC_BASE) + NUMW'(sec_idx);
      end
    end else if (pri_found) begin
      grp_valid = 1'b1;
      grp_num   = NUMW'(PRI_BASE) + NUMW'(pri_idx);
    end
  end
endmodule

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs #(
  parameter int W  = 8,
  parameter int N  = 4,
  localparam int AW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [N-1:0][W-1:0] masks
);
  logic [N-1:0][W-1:0] mask_q;
  logic [N-1:0][W-1:0] mask_d;
  logic [N-1:0]        mask_en;

  always_comb begin
    mask_d  = mask_q;
    mask_en = '0;
    for (int i = 0; i < N; i++) begin
      if (we && (addr == AW'(i))) begin
        mask_en[i] = 1'b1;
        mask_d[i]  = wdata;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= '0;
      end else if (mask_en[g]) begin
        mask_q[g] <= mask_d[g];
      end
    end
  end

  assign rdata = mask_q[addr];
  assign masks = mask_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mask_q[$past(addr)] == $past(wdata))) else $error("write lost"); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask_q)) else $error("mask changed without write"); // R8
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int IRQ_BASE = 8,
  parameter int MAP_BIT0 = 2,
  parameter int MAP_BIT1 = 3,
  localparam int W       = irqc_pkg::GROUP_W,
  localparam int NG      = irqc_pkg::N_GROUPS,
  localparam int NM      = irqc_pkg::N_MASKS,
  localparam int AW      = $clog2(NM),
  localparam int NUMW    = $clog2(IRQ_BASE + NM * W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    loc0_stat,
  input  logic [W-1:0]    loc1_stat,
  input  logic [W-1:0]    map_stat,
  input  logic            tmr_req,
  input  logic            buserr_req,
  input  logic            ctr0_req,
  input  logic            ctr1_req,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata,
  output logic            irq_valid,
  output logic [2:0]      irq_cat,
  output logic [NUMW-1:0] irq_num
);
  import irqc_pkg::*;

  logic       rst_meta_n;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NM-1:0][W-1:0] masks;
  logic [NG-1:0][W-1:0] stats;
  logic [NG-1:0]        g_valid;
  logic [NG-1:0][NUMW-1:0] g_num;

  assign stats[0] = loc0_stat;
  assign stats[1] = loc1_stat;

  irqc_mask_regs #(.W(W), .N(NM)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .masks (masks)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    irqc_group #(
      .W        (W),
      .MAP_BIT  ((g == 0) ? MAP_BIT0 : MAP_BIT1),
      .PRI_BASE (IRQ_BASE + g * W),
      .SEC_BASE (IRQ_BASE + (NG + g) * W),
      .NUMW     (NUMW)
    ) u_grp (
      .stat      (stats[g]),
      .mask      (masks[g]),
      .map_stat  (map_stat),
      .sec_mask  (masks[NG + g]),
      .grp_valid (g_valid[g]),
      .grp_num   (g_num[g])
    );
  end

  irq_cat_e        cat_d, cat_q;
  logic [NUMW-1:0] num_d, num_q;
  logic            valid_d, valid_q;

  always_comb begin
    cat_d = CAT_NONE;
    num_d = '0;
    if (tmr_req) begin
      cat_d = CAT_TIMER;
    end else if (g_valid[0]) begin
      cat_d = CAT_LOCAL0;
      num_d = g_num[0];
    end else if (g_valid[1]) begin
      cat_d = CAT_LOCAL1;
      num_d = g_num[1];
    end else if (buserr_req) begin
      cat_d = CAT_BUSERR;
    end else if (ctr0_req || ctr1_req) begin
      cat_d = CAT_COUNTER;
    end
    valid_d = (cat_d != CAT_NONE);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cat_q   <= CAT_NONE;
      num_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cat_q   <= cat_d;
      num_q   <= num_d;
      valid_q <= valid_d;
    end
  end

  assign irq_cat   = cat_q;
  assign irq_num   = num_q;
  assign irq_valid = valid_q;

  AST_TIMER_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_req |=> (irq_cat == 3'd1 && irq_num == '0)) else $error("timer lost"); // R6

  AST_LOCAL0_PASSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tmr_req && g_valid[0]) |=> (irq_cat == 3'd2 && irq_num == $past(g_num[0])))
    else $error("local0 lost"); // R6

  AST_BUSERR_ORDER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buserr_req && !tmr_req && g_valid == '0) |=> irq_cat == 3'd4)
    else $error("bus error order"); // R6

  AST_COUNTER_LAST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((ctr0_req || ctr1_req) && !tmr_req && !buserr_req && g_valid == '0) |=> irq_cat == 3'd5)
    else $error("counter lost"); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tmr_req && !buserr_req && !ctr0_req && !ctr1_req && g_valid == '0) |=> !irq_valid)
    else $error("spurious valid"); // R10

  AST_LOCAL_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_cat == 3'd2 || irq_cat == 3'd3) |-> (irq_num >= NUMW'(IRQ_BASE)))
    else $error("local number out of range"); // R2
endmodule

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic [7:0] loc0_stat, loc1_stat, map_stat;
  logic       tmr_req, buserr_req, ctr0_req, ctr1_req;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_valid;
  logic [2:0] irq_cat;
  logic [5:0] irq_num;

  int checks = 0;
  int errors = 0;

  cascade_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .loc0_stat(loc0_stat), .loc1_stat(loc1_stat), .map_stat(map_stat),
    .tmr_req(tmr_req), .buserr_req(buserr_req), .ctr0_req(ctr0_req), .ctr1_req(ctr1_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_cat(irq_cat), .irq_num(irq_num)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fields: m0 m1 s0 s1 | l0 l1 map | {tmr,be,c0,c1} | cat | num
  localparam int NV = 13;
  localparam logic [71:0] TBL [NV] = '{
    {8'hFF,8'hFF,8'hFF,8'hFF, 8'h81,8'h00,8'h00, 4'b0000, 4'd2, 8'd15}, // R2
    {8'h01,8'h00,8'h00,8'h00, 8'h81,8'h00,8'h00, 4'b0000, 4'd2, 8'd8 }, // R1
    {8'hFF,8'h00,8'h10,8'h00, 8'h84,8'h00,8'h30, 4'b0000, 4'd2, 8'd28}, // R3
    {8'h00,8'hFF,8'h00,8'h02, 8'h00,8'h88,8'h03, 4'b0000, 4'd3, 8'd33}, // R4
    {8'hFF,8'hFF,8'h00,8'h00, 8'h84,8'h01,8'hFF, 4'b0000, 4'd3, 8'd16}, // R5
    {8'hFF,8'h00,8'h00,8'h00, 8'h04,8'h00,8'hFF, 4'b0100, 4'd4, 8'd0 }, // R5
    {8'hFF,8'h00,8'h00,8'h00, 8'h01,8'h00,8'h00, 4'b1111, 4'd1, 8'd0 }, // R6
    {8'hFF,8'hFF,8'h00,8'h00, 8'h40,8'h80,8'h00, 4'b0111, 4'd2, 8'd14}, // R6
    {8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 4'b0001, 4'd5, 8'd0 }, // R7
    {8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 4'b0010, 4'd5, 8'd0 }, // R7
    {8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 4'b0110, 4'd4, 8'd0 }, // R6
    {8'h00,8'h00,8'h00,8'h00, 8'hFF,8'hFF,8'hFF, 4'b0000, 4'd0, 8'd0 }, // R1
    {8'hFB,8'h00,8'hFF,8'h00, 8'h06,8'h00,8'hFF, 4'b0000, 4'd2, 8'd9 }  // R3
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_in();
    loc0_stat = '0; loc1_stat = '0; map_stat = '0;
    tmr_req = 0; buserr_req = 0; ctr0_req = 0; ctr1_req = 0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    clear_in();
    tmr_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9 valid", irq_valid, 0);
    check("R9 cat", irq_cat, 0);
    check("R9 num", irq_num, 0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check("R9 mask", reg_rdata, 0);
    end
    tmr_req = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [71:0] e;
      e = TBL[v];
      wr(2'd0, e[71:64]); wr(2'd1, e[63:56]); wr(2'd2, e[55:48]); wr(2'd3, e[47:40]);
      loc0_stat = e[39:32]; loc1_stat = e[31:24]; map_stat = e[23:16];
      tmr_req = e[15]; buserr_req = e[14]; ctr0_req = e[13]; ctr1_req = e[12];
      @(negedge clk);
      check($sformatf("R6 vec%0d cat", v), irq_cat, int'(e[11:8]));
      check($sformatf("R2 vec%0d num", v), irq_num, int'(e[7:0]));
      check($sformatf("R10 vec%0d valid", v), irq_valid, int'(e[11:8] != 0));
    end

    // R8: readback of each register
    wr(2'd0, 8'hA5); wr(2'd1, 8'h5A); wr(2'd2, 8'h3C); wr(2'd3, 8'hC3);
    reg_addr = 2'd0; #1; check("R8 rd0", reg_rdata, 8'hA5);
    reg_addr = 2'd1; #1; check("R8 rd1", reg_rdata, 8'h5A);
    reg_addr = 2'd2; #1; check("R8 rd2", reg_rdata, 8'h3C);
    reg_addr = 2'd3; #1; check("R8 rd3", reg_rdata, 8'hC3);

    // R10: output lags by one edge; mask write and status change in same cycle
    clear_in();
    wr(2'd0, 8'h00);
    @(negedge clk);
    check("R10 idle", irq_valid, 0);
    loc0_stat = 8'h20;
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h20;
    #1;
    check("R10 before edge", irq_valid, 0);
    @(negedge clk);
    reg_we = 1'b0;
    check("R10 masked at edge", irq_valid, 0);
    @(negedge clk);
    check("R10 after edge cat", irq_cat, 2);
    check("R10 after edge num", irq_num, 13);

    // R9: asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R9 async valid", irq_valid, 0);
    reg_addr = 2'd0; #1;
    check("R9 async mask", reg_rdata, 0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule